// File: doc/BRIEF.md
# Filtered Fault Input Shutdown Detector

This block watches one active-low external fault pin. When the chosen detection condition appears on the pin it sets a sticky request flag. The condition is either a falling edge or a run of sixteen consecutive low samples. The samples are taken on a tick from a free-running prescaler that runs at one of three rates. The pin first passes through a two-flop synchroniser. Every later decision uses the synchronised level.

A single 16-bit control/status register sits on a simple synchronous bus. Every access is a full word. The register holds the detection mode, an interrupt enable, a float enable and the flag. The block drives two outputs. An interrupt request is raised while the flag and the interrupt enable are both set. A float request, which tells output drivers to go high-impedance, is raised while the flag and the float enable are both set.

The mode can be written only once after reset. The flag follows a read-then-clear rule, so software cannot clear an event it has not seen.

Top module: `fault_shutdown_det`

## Requirements
- R1: After reset the register reads 0x0000 and both `irq_o` and `hiz_req_o` are 0.
- R2: Mode bits [1:0] select detection. 00 detects a falling edge. 01, 10 and 11 detect 16 consecutive low samples taken once every 8, 16 and 128 clocks respectively.
- R3: Bit 12 is the flag. It becomes 1 on the clock edge after the detection condition is seen at the output of a two-flop input synchroniser. In edge mode, a pin that goes low before clock edge k shows the flag after edge k+2.
- R4: `irq_o` is 1 exactly when bit 8 (interrupt enable) and the flag are both 1.
- R5: `hiz_req_o` is 1 exactly when bit 9 (float enable) and the flag are both 1.
- R6: The first write after reset loads bits [1:0], whatever its value. Bits [1:0] then ignore every later write until the next reset. Bits 8 and 9 take every write.
- R7: Bits 15:13, 11:10 and 7:2 always read 0, whatever is written to them.
- R8: A write with bit 12 = 0 clears the flag only if a read (bus_en_i=1, bus_we_i=0) returned the flag as 1 after the last clear. A write with bit 12 = 1 never changes the flag. A write with bit 12 = 0 and no such prior read leaves the flag set.
- R9: If a detection occurs in the same cycle as a valid clearing write, the flag stays 1.
- R10: A high sample restarts the low-sample count. After a clear, the flag sets again only on a new falling edge, or after 16 new low samples counted from the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fault_n_i | input | 1 | Asynchronous active-low fault pin |
| bus_en_i | input | 1 | Bus access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Register contents, valid continuously |
| irq_o | output | 1 | Interrupt request |
| hiz_req_o | output | 1 | Request for output pins to float |

## Verification
The bench targets the clearing rule from three sides: a write of 0 with no prior read, a write of 1 after a read, and a clearing write that lands in the same cycle as a new falling edge. A design that checks only the written bit would drop unseen events. A design that lets the clear win would lose a fault that arrived during the clear. Each filter rate is tested just under and just over 16 sample periods, so a count that is off by one or a wrong prescale fires a check. Glitch-high and held-low-across-a-clear patterns catch a counter that is not restarted by a high sample or by the clear. A second write to the mode field catches a lock that does not hold.

// File: rtl/fsd_pkg.sv
// Shared constants and types for the fault shutdown detector.
// Assumes a 16-bit register with fixed bit positions for fields decoded by software.
package fsd_pkg;
    localparam int REG_W    = 16;
    localparam int IE_BIT   = 8;
    localparam int HZ_BIT   = 9;
    localparam int FLAG_BIT = 12;
    localparam int RUN_LEN  = 16;
    localparam int DIV_FAST = 8;
    localparam int DIV_MID  = 16;
    localparam int DIV_SLOW = 128;

    typedef enum logic [1:0] {
        DET_EDGE   = 2'b00,
        DET_FAST   = 2'b01,
        DET_MID    = 2'b10,
        DET_SLOW   = 2'b11
    } det_mode_e;
endpackage

// File: rtl/fsd_sync.sv
// Multi-stage synchroniser for an asynchronous level.
// Assumes the idle level is 1 (inactive fault), which is the reset value of each stage.
module fsd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] stage_q;

    // Shift the pin level through the stages.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= '1;
        else        stage_q <= {stage_q[STAGES-2:0], d_i};
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/fsd_filter.sv
// Detection engine: a falling-edge detector or a run-of-lows counter clocked by a
// prescaler tick. Outputs a one-cycle detect pulse. Assumes sync_i is already synchronised.
module fsd_filter import fsd_pkg::*; #(
    parameter int RUN     = RUN_LEN,
    parameter int DIV_A   = DIV_FAST,
    parameter int DIV_B   = DIV_MID,
    parameter int DIV_C   = DIV_SLOW
) (
    input  logic      clk,
    input  logic      rst_n,
    input  det_mode_e mode_i,
    input  logic      sync_i,
    input  logic      restart_i,
    output logic      det_o
);
    localparam int PRE_W = $clog2(DIV_C);
    localparam int RCW   = $clog2(RUN + 1);
    localparam logic [RCW-1:0] RUN_LAST = RCW'(RUN - 1);
    localparam logic [RCW-1:0] RUN_MAX  = RCW'(RUN);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;
    logic             tick;
    logic             prev_q;
    logic [RCW-1:0]   run_q;
    logic             edge_hit;
    logic             run_hit;

    // Free-running prescaler counter.
    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_q + 1'b1;
    end

    // Pick the tick mask for the selected sample rate.
    always_comb begin
        case (mode_i)
            DET_FAST: mask = PRE_W'(DIV_A - 1);
            DET_MID:  mask = PRE_W'(DIV_B - 1);
            default:  mask = PRE_W'(DIV_C - 1);
        endcase
    end

    assign tick = ((pre_q & mask) == mask);

    // Remember the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= sync_i;
    end

    // Count consecutive low samples, saturating; a high sample or a restart zeroes it.
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i) run_q <= '0;
        else if (tick) begin
            if (sync_i)              run_q <= '0;
            else if (run_q != RUN_MAX) run_q <= run_q + 1'b1;
        end
    end

    assign edge_hit = prev_q & ~sync_i;
    assign run_hit  = tick & ~sync_i & (run_q == RUN_LAST);
    assign det_o    = (mode_i == DET_EDGE) ? edge_hit : run_hit;

    // R10
    run_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && sync_i && !restart_i) |=> (run_q == '0));

    // R2
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/fsd_regs.sv
// Control/status register: write-once mode, two enables, and a read-then-clear flag.
// Assumes one-cycle full-word accesses; read data is the live register contents.
module fsd_regs import fsd_pkg::*; (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_en_i,
    input  logic             bus_we_i,
    input  logic [REG_W-1:0] bus_wdata_i,
    input  logic             det_i,
    output logic [REG_W-1:0] rdata_o,
    output det_mode_e        mode_o,
    output logic             restart_o,
    output logic             irq_o,
    output logic             hiz_o
);
    logic      wr, rd, clr_ok;
    logic      flag_q, arm_q, locked_q, ie_q, hz_q;
    det_mode_e mode_q;
    logic      unused_rsvd;

    assign wr     = bus_en_i & bus_we_i;
    assign rd     = bus_en_i & ~bus_we_i;
    assign clr_ok = wr & ~bus_wdata_i[FLAG_BIT] & arm_q;
    assign unused_rsvd = ^{bus_wdata_i[15:13], bus_wdata_i[11:10], bus_wdata_i[7:2]};

    // Sticky flag: detection wins over a clearing write.
    always_ff @(posedge clk) begin
        if (!rst_n)      flag_q <= 1'b0;
        else if (det_i)  flag_q <= 1'b1;
        else if (clr_ok) flag_q <= 1'b0;
    end

    // Arm bit: records that a read returned the flag as 1.
    always_ff @(posedge clk) begin
        if (!rst_n)            arm_q <= 1'b0;
        else if (clr_ok)       arm_q <= 1'b0;
        else if (rd && flag_q) arm_q <= 1'b1;
    end

    // Mode field: loaded by the first write after reset, then locked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= DET_EDGE;
            locked_q <= 1'b0;
        end else if (wr && !locked_q) begin
            mode_q   <= det_mode_e'(bus_wdata_i[1:0]);
            locked_q <= 1'b1;
        end
    end

    // Enable bits: rewritten on every write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q <= 1'b0;
            hz_q <= 1'b0;
        end else if (wr) begin
            ie_q <= bus_wdata_i[IE_BIT];
            hz_q <= bus_wdata_i[HZ_BIT];
        end
    end

    // Assemble read data; reserved positions stay zero.
    always_comb begin
        rdata_o           = '0;
        rdata_o[1:0]      = mode_q;
        rdata_o[IE_BIT]   = ie_q;
        rdata_o[HZ_BIT]   = hz_q;
        rdata_o[FLAG_BIT] = flag_q;
    end

    assign mode_o    = mode_q;
    assign restart_o = clr_ok;
    assign irq_o     = flag_q & ie_q;
    assign hiz_o     = flag_q & hz_q;

    // R8
    flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_q) |-> $past(bus_en_i && bus_we_i && !bus_wdata_i[FLAG_BIT] && arm_q));

    // R3
    flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(det_i));

    // R6
    mode_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked_q |=> $stable(mode_q));

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        det_i |=> flag_q);
endmodule

// File: rtl/fault_shutdown_det.sv
// Top level: synchroniser, detection engine and register.
// Assumes fault_n_i is asynchronous and active low.
module fault_shutdown_det import fsd_pkg::*; #(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fault_n_i,
    input  logic             bus_en_i,
    input  logic             bus_we_i,
    input  logic [REG_W-1:0] bus_wdata_i,
    output logic [REG_W-1:0] bus_rdata_o,
    output logic             irq_o,
    output logic             hiz_req_o
);
    logic      sync_lvl;
    logic      det;
    logic      restart;
    det_mode_e mode;

    fsd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (fault_n_i),
        .q_o   (sync_lvl)
    );

    fsd_filter u_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_i    (mode),
        .sync_i    (sync_lvl),
        .restart_i (restart),
        .det_o     (det)
    );

    fsd_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_en_i    (bus_en_i),
        .bus_we_i    (bus_we_i),
        .bus_wdata_i (bus_wdata_i),
        .det_i       (det),
        .rdata_o     (bus_rdata_o),
        .mode_o      (mode),
        .restart_o   (restart),
        .irq_o       (irq_o),
        .hiz_o       (hiz_req_o)
    );
endmodule

// File: tb/test_fault_shutdown_det.sv
`timescale 1ns/1ps
// Bench: behavioural per-clock model plus directed checks at the ports.
module test_fault_shutdown_det;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fault_n = 1'b1;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        irq, hiz;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    fault_shutdown_det i_fault_shutdown_det (
        .clk(clk), .rst_n(rst_n), .fault_n_i(fault_n),
        .bus_en_i(bus_en), .bus_we_i(bus_we), .bus_wdata_i(bus_wdata),
        .bus_rdata_o(bus_rdata), .irq_o(irq), .hiz_req_o(hiz)
    );

    always #10 clk = ~clk;

    // Behavioural model state
    bit m_s1 = 1, m_s2 = 1, m_s3 = 1;
    int m_cyc = 0, m_run = 0, m_mode = 0;
    bit m_flag = 0, m_arm = 0, m_lock = 0, m_ie = 0, m_hz = 0;
    int  div, n_run;
    bit  tick, low, det, clr, rdv, wrv, n_flag, n_arm;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = 1; m_s2 = 1; m_s3 = 1; m_cyc = 0; m_run = 0; m_mode = 0;
            m_flag = 0; m_arm = 0; m_lock = 0; m_ie = 0; m_hz = 0;
        end else begin
            div  = (m_mode == 1) ? 8 : (m_mode == 2) ? 16 : 128;
            tick = ((m_cyc % div) == div - 1);
            low  = !m_s2;
            wrv  = bus_en && bus_we;
            rdv  = bus_en && !bus_we;
            clr  = wrv && !bus_wdata[12] && m_arm;
            det  = (m_mode == 0) ? (m_s3 && !m_s2) : (tick && low && m_run == 15);
            if (clr) n_run = 0;
            else if (tick) n_run = low ? ((m_run < 16) ? m_run + 1 : 16) : 0;
            else n_run = m_run;
            n_arm  = clr ? 0 : ((rdv && m_flag) ? 1 : m_arm);
            n_flag = det ? 1 : (clr ? 0 : m_flag);
            if (wrv && !m_lock) begin m_mode = int'(bus_wdata[1:0]); m_lock = 1; end
            if (wrv) begin m_ie = bus_wdata[8]; m_hz = bus_wdata[9]; end
            m_run = n_run; m_arm = n_arm; m_flag = n_flag;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = fault_n;
            m_cyc++;
        end
    end

    task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Per-clock comparison against the model
    always @(posedge clk) begin
        #5;
        if (!done) begin
            chk("R4 R5 R7 R8", "model rdata", bus_rdata,
                16'((int'(m_flag) << 12) | (int'(m_hz) << 9) | (int'(m_ie) << 8) | m_mode));
            chk("R4", "model irq", {15'h0, irq}, {15'h0, m_flag & m_ie});
            chk("R5", "model hiz", {15'h0, hiz}, {15'h0, m_flag & m_hz});
        end
    end

    // Tasks start and end just after a falling clock edge
    task automatic do_reset();
        fault_n = 1; bus_en = 0; bus_we = 0; rst_n = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic wr(input logic [15:0] d);
        bus_en = 1; bus_we = 1; bus_wdata = d;
        @(negedge clk);
        bus_en = 0; bus_we = 0; bus_wdata = 16'h0;
    endtask

    task automatic rd(output logic [15:0] d);
        bus_en = 1; bus_we = 0;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_en = 0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [15:0] r;
        @(negedge clk);
        // ---- Edge mode ----
        do_reset();
        chk("R1", "reset rdata", bus_rdata, 16'h0000);
        chk("R1", "reset irq/hiz", {14'h0, irq, hiz}, 16'h0);
        wr(16'hEFFC);
        rd(r); chk("R7", "reserved bits read zero", r, 16'h0300);
        wr(16'h0003);
        rd(r); chk("R6", "mode ignores second write", r, 16'h0000);
        wr(16'h0300);
        fault_n = 0; wait_cyc(3);
        chk("R3", "flag after edge", bus_rdata, 16'h1300);
        chk("R4", "irq with enable", {15'h0, irq}, 16'h1);
        chk("R5", "hiz with enable", {15'h0, hiz}, 16'h1);
        fault_n = 1;
        wr(16'h0300); wait_cyc(1);
        chk("R8", "write 0 without read", bus_rdata, 16'h1300);
        rd(r);
        wr(16'h1300); wait_cyc(1);
        chk("R8", "write 1 after read", bus_rdata, 16'h1300);
        wr(16'h0300); wait_cyc(1);
        chk("R8", "cleared after read", bus_rdata, 16'h0300);
        chk("R4", "irq low after clear", {15'h0, irq}, 16'h0);
        fault_n = 0; wait_cyc(4);
        rd(r); chk("R3", "second edge sets", r, 16'h1300);
        wr(16'h0300); wait_cyc(10);
        chk("R10", "held low no re-set", bus_rdata, 16'h0300);
        fault_n = 1; wait_cyc(4);
        fault_n = 0; wait_cyc(4);
        wr(16'h0200); wait_cyc(1);
        chk("R4", "irq gated off", {14'h0, irq, hiz}, 16'h1);
        wr(16'h0100); wait_cyc(1);
        chk("R5", "hiz gated off", {14'h0, irq, hiz}, 16'h2);
        fault_n = 1; wait_cyc(4);
        rd(r);
        fault_n = 0; wait_cyc(2);
        wr(16'h0100); wait_cyc(2);
        chk("R9", "set wins over clear", bus_rdata, 16'h1100);

        // ---- Filter, every 8 clocks ----
        do_reset();
        wr(16'h0301);
        fault_n = 0; wait_cyc(120);
        chk("R2", "div8 before 16 samples", bus_rdata, 16'h0301);
        wait_cyc(20);
        chk("R2", "div8 after 16 samples", bus_rdata, 16'h1301);
        rd(r); wr(16'h0300); wait_cyc(100);
        chk("R10", "count restarts at clear", bus_rdata, 16'h0301);
        wait_cyc(40);
        chk("R10", "fresh run after clear", bus_rdata, 16'h1301);
        rd(r); wr(16'h0301); wait_cyc(80);
        fault_n = 1; wait_cyc(20);
        fault_n = 0; wait_cyc(120);
        chk("R10", "high sample restarts", bus_rdata, 16'h0301);
        wait_cyc(20);
        chk("R10", "run after glitch", bus_rdata, 16'h1301);

        // ---- Filter, every 16 clocks ----
        do_reset();
        wr(16'h0302);
        fault_n = 0; wait_cyc(235);
        chk("R2", "div16 before 16 samples", bus_rdata, 16'h0302);
        wait_cyc(40);
        chk("R2", "div16 after 16 samples", bus_rdata, 16'h1302);

        // ---- Filter, every 128 clocks ----
        do_reset();
        wr(16'h0303);
        fault_n = 0; wait_cyc(1900);
        chk("R2", "div128 before 16 samples", bus_rdata, 16'h0303);
        wait_cyc(200);
        chk("R2", "div128 after 16 samples", bus_rdata, 16'h1303);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule